// File: doc/BRIEF.md
# Back-Pressure Wrapper for Ready-Less Processing Pipelines

This block places full valid/ready flow control around a processing stage that cannot stall. Upstream words enter through a stream slave port. They pass straight on to the processing, which sees only data and a valid strobe. Whatever the processing emits comes back as data plus valid, again with no ready, and lands in an internal synchronous FIFO. The FIFO feeds a stream master port that does honour a downstream ready.

The processing can never be told to stop, so the wrapper must stop feeding it early enough. The input ready is a registered decision based on the FIFO fill level. It falls as soon as the fill level rises above `ABSORB + 2`. The FIFO holds `(ABSORB + 2) * 2` words, which leaves room for every sample still travelling through the processing after the input is cut off. `ABSORB` is the largest number of samples the processing may emit after its input valid drops; for a plain pipeline it is the pipeline depth. The threshold is set so that a sink that is always ready sees one word per clock with no bubbles. Input and output word widths are separate parameters, because the processing may change the word size.

Top module: `pbw_top`

## Requirements
- R1: `proc_valid` is high exactly when `up_valid` and `up_ready` are both high, and `proc_data` equals `up_data` in the same cycle.
- R2: While `rst` (active-high, synchronous) is high, and in the first cycle after it falls, `up_ready` and `dn_valid` are low.
- R3: If the processing emits at most `ABSORB` samples after `proc_valid` drops, a `ret_valid` never arrives while the FIFO holds `(ABSORB+2)*2` words.
- R4: `up_ready` in a cycle is high exactly when the FIFO fill level at the start of that cycle is at most `ABSORB+2`. With a sink held not ready, a source that is always valid and a processing latency of `ABSORB`, exactly `2*ABSORB+3` words are accepted before `up_ready` stays low.
- R5: With `dn_ready` held high, `up_ready` stays high every cycle. Once the first word emerges, `dn_valid` is high every cycle while the source stays valid.
- R6: `dn_valid` is high whenever the FIFO holds a word. `dn_data` is the oldest stored word, and a word is removed in each cycle where `dn_valid` and `dn_ready` are both high. Words leave in arrival order, none lost or duplicated.
- R7: While `dn_valid` is high and `dn_ready` is low, `dn_valid` stays high and `dn_data` stays unchanged in the next cycle.
- R8: A word returned with `ret_valid` in cycle n into an empty FIFO is shown on `dn_data` with `dn_valid` in cycle n+1.
- R9: Input words are `IN_W` bits and output words are `OUT_W` bits, set independently; the full `OUT_W`-bit returned word reaches `dn_data` unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_data | input | IN_W | Upstream word |
| up_valid | input | 1 | Upstream word present |
| up_ready | output | 1 | Wrapper accepts the upstream word |
| proc_data | output | IN_W | Word sent to the processing |
| proc_valid | output | 1 | Strobe for the word sent to the processing |
| ret_data | input | OUT_W | Word returned by the processing |
| ret_valid | input | 1 | Strobe for the returned word |
| dn_data | output | OUT_W | Downstream word (oldest FIFO entry) |
| dn_valid | output | 1 | FIFO not empty |
| dn_ready | input | 1 | Downstream sink takes the word |

## Verification
The processing-facing outputs respond in the same cycle as the upstream inputs. A returned word reaches the output one cycle after it arrives, so with the bench's four-stage delay line the first output comes five cycles after the first accepted input. The `up_ready` decision follows the fill level with one register, which is why a stalled sink lets exactly `2*ABSORB+3` words in. Inputs change one nanosecond after a rising edge and every output is sampled at the falling edge. The bench counts those edges from the accepting cycle, so each check lands in the cycle where its result is due.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    // Buffer depth needed for a given absorb count: the in-flight samples,
    // one cycle of FIFO write latency and one cycle of registered ready,
    // doubled so that a fully streaming sink never sees a bubble.
    function automatic int unsigned buf_depth(input int unsigned absorb);
        return (absorb + 2) * 2;
    endfunction

    // Fill level above which the input side is closed.
    function automatic int unsigned open_limit(input int unsigned absorb);
        return absorb + 2;
    endfunction

endpackage

// File: rtl/pbw_store.sv
module pbw_store #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [W-1:0]                  wr_data,
    input  logic                          rd_en,
    output logic [W-1:0]                  rd_data,
    output logic                          empty,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    lvl_q,
    output logic [$clog2(DEPTH+1)-1:0]    lvl_d
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_q, st_d;
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp_inc, rp_inc;
    logic do_wr, do_rd;

    // Pointer advance: plain wrap for power-of-two depths, compare otherwise.
    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            assign wp_inc = st_q.wp + 1'b1;
            assign rp_inc = st_q.rp + 1'b1;
        end else begin : g_mod
            localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
            assign wp_inc = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            assign rp_inc = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
    endgenerate

    always_comb begin
        st_d  = st_q;
        do_wr = wr_en && (st_q.cnt != CNT_MAX);
        do_rd = rd_en && (st_q.cnt != '0);
        if (do_wr) st_d.wp = wp_inc;
        if (do_rd) st_d.rp = rp_inc;
        unique case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[st_q.wp] <= wr_data;
        end
    end

    assign rd_data = mem[st_q.rp];
    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_MAX);
    assign lvl_q   = st_q.cnt;
    assign lvl_d   = st_d.cnt;

endmodule

// File: rtl/pbw_gate.sv
module pbw_gate #(
    parameter int unsigned CW    = 4,
    parameter int unsigned LIMIT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] lvl_d,
    input  logic          up_valid,
    output logic          up_ready,
    output logic          proc_valid
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic open;
    } gate_t;

    gate_t g_q, g_d;

    // The ready for the next cycle follows the fill level the FIFO will have
    // after this edge, so it equals "level at start of cycle <= LIMIT".
    always_comb begin
        g_d      = g_q;
        g_d.open = (lvl_d <= LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign up_ready   = g_q.open;
    assign proc_valid = up_valid && g_q.open;

endmodule

// File: rtl/pbw_top.sv
module pbw_top #(
    parameter int unsigned IN_W   = 8,
    parameter int unsigned OUT_W  = 12,
    parameter int unsigned ABSORB = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  up_data,
    input  logic             up_valid,
    output logic             up_ready,
    output logic [IN_W-1:0]  proc_data,
    output logic             proc_valid,
    input  logic [OUT_W-1:0] ret_data,
    input  logic             ret_valid,
    output logic [OUT_W-1:0] dn_data,
    output logic             dn_valid,
    input  logic             dn_ready
);
    localparam int unsigned DEPTH = pbw_pkg::buf_depth(ABSORB);
    localparam int unsigned LIMIT = pbw_pkg::open_limit(ABSORB);
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic          fifo_empty;
    logic          fifo_full;
    logic [CW-1:0] fifo_lvl;
    logic [CW-1:0] fifo_lvl_d;

    pbw_store #(
        .W     (OUT_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ret_valid),
        .wr_data (ret_data),
        .rd_en   (dn_ready),
        .rd_data (dn_data),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .lvl_q   (fifo_lvl),
        .lvl_d   (fifo_lvl_d)
    );

    pbw_gate #(
        .CW    (CW),
        .LIMIT (LIMIT)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .lvl_d      (fifo_lvl_d),
        .up_valid   (up_valid),
        .up_ready   (up_ready),
        .proc_valid (proc_valid)
    );

    assign proc_data = up_data;
    assign dn_valid  = !fifo_empty;

endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
    parameter int unsigned OUT_W  = 12,
    parameter int unsigned ABSORB = 4,
    parameter int unsigned CW     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             up_ready,
    input logic             ret_valid,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic [OUT_W-1:0] dn_data,
    input logic             full,
    input logic [CW-1:0]    level
);
    localparam logic [CW-1:0] LIM = CW'(ABSORB + 2);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> !full);                                       // R3

    AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        up_ready |-> (level <= LIM));                               // R4

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));  // R7

    AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!up_ready && !dn_valid));                   // R2

    AST_RET_SHOWN: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> dn_valid);                                    // R8

endmodule

bind pbw_top pbw_checker #(
    .OUT_W  (OUT_W),
    .ABSORB (ABSORB),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .up_ready  (up_ready),
    .ret_valid (ret_valid),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_data   (dn_data),
    .full      (fifo_full),
    .level     (fifo_lvl)
);

// File: tb/sim_pbw_top.sv
`timescale 1ns/1ps
module sim_pbw_top;
    localparam int IN_W   = 8;
    localparam int OUT_W  = 12;
    localparam int ABSORB = 4;
    localparam int LAT    = 4;
    localparam int DEPTH  = (ABSORB + 2) * 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IN_W-1:0]  up_data = '0;
    logic             up_valid = 1'b0;
    logic             up_ready;
    logic [IN_W-1:0]  proc_data;
    logic             proc_valid;
    logic [OUT_W-1:0] ret_data;
    logic             ret_valid;
    logic [OUT_W-1:0] dn_data;
    logic             dn_valid;
    logic             dn_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int acc_cnt = 0;
    int out_cnt = 0;
    bit hs = 1'b0;
    bit done = 1'b0;
    bit prev_stall = 1'b0;
    logic [OUT_W-1:0] prev_data = '0;
    logic [OUT_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    pbw_top #(.IN_W(IN_W), .OUT_W(OUT_W), .ABSORB(ABSORB)) u0 (
        .clk(clk), .rst(rst),
        .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
        .proc_data(proc_data), .proc_valid(proc_valid),
        .ret_data(ret_data), .ret_valid(ret_valid),
        .dn_data(dn_data), .dn_valid(dn_valid), .dn_ready(dn_ready)
    );

    // Processing model: fixed-latency delay line that widens the word.
    function automatic logic [OUT_W-1:0] fx(input logic [IN_W-1:0] x);
        return {x, x[3:0] ^ 4'hA};
    endfunction

    logic [LAT-1:0]  pv = '0;
    logic [IN_W-1:0] pd [LAT];
    always @(posedge clk) begin
        for (int i = LAT - 1; i > 0; i--) begin
            pv[i] <= pv[i-1];
            pd[i] <= pd[i-1];
        end
        pv[0] <= proc_valid;
        pd[0] <= proc_data;
    end
    assign ret_valid = pv[LAT-1];
    assign ret_data  = fx(pd[LAT-1]);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor at the falling edge: scoreboard and hold check.
    always @(negedge clk) begin
        hs = up_valid && up_ready;
        if (!rst) begin
            if (hs) begin
                exp_q.push_back(fx(up_data));
                acc_cnt++;
            end
            if (prev_stall) begin
                chk(dn_valid && (dn_data == prev_data), "R7", "held word",
                    longint'(dn_data), longint'(prev_data));
            end
            if (dn_valid && dn_ready) begin
                out_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected output", longint'(dn_data), 0);
                end else begin
                    logic [OUT_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(dn_data == e, "R9", "output word (R6 order)",
                        longint'(dn_data), longint'(e));
                end
            end
            prev_stall = dn_valid && !dn_ready;
            prev_data  = dn_data;
        end
    end

    // Source advances its word after each accepted handshake.
    always @(posedge clk) begin
        #1;
        if (hs) up_data = up_data + 1'b1;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!up_ready && !dn_valid, "R2", "idle in reset",
            {up_ready, dn_valid}, 0);
        step();
        rst = 1'b0;
        @(negedge clk);
        chk(!up_ready && !dn_valid, "R2", "idle after reset",
            {up_ready, dn_valid}, 0);
        @(negedge clk);
        chk(up_ready == 1'b1, "R4", "ready opens on empty FIFO", up_ready, 1);
    endtask

    task automatic t_drain();
        step();
        up_valid = 1'b0;
        dn_ready = 1'b1;
        repeat (LAT + DEPTH + 6) step();
        chk(exp_q.size() == 0, "R6", "all words delivered", exp_q.size(), 0);
    endtask

    task automatic t_pass();
        step();
        up_valid = 1'b0;
        @(negedge clk);
        chk(proc_valid == 1'b0, "R1", "proc_valid without up_valid", proc_valid, 0);
        step();
        up_valid = 1'b1;
        @(negedge clk);
        chk(proc_valid == (up_valid && up_ready), "R1", "proc_valid",
            proc_valid, up_valid && up_ready);
        chk(proc_data == up_data, "R1", "proc_data", proc_data, up_data);
        t_drain();
    endtask

    task automatic t_stream();
        int k;
        int not_ready;
        int gaps;
        step();
        dn_ready = 1'b1;
        up_valid = 1'b1;
        @(negedge clk);
        k = 0;
        while (!dn_valid && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk(k == LAT + 1, "R8", "first output delay", k, LAT + 1);
        not_ready = 0;
        gaps = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!up_ready) not_ready++;
            if (!dn_valid) gaps++;
        end
        chk(not_ready == 0, "R5", "stall cycles on input", not_ready, 0);
        chk(gaps == 0, "R5", "bubbles on output", gaps, 0);
        t_drain();
    endtask

    task automatic t_stall();
        int a0;
        int o0;
        step();
        a0 = acc_cnt;
        o0 = out_cnt;
        dn_ready = 1'b0;
        up_valid = 1'b1;
        repeat (30) step();
        @(negedge clk);
        chk(acc_cnt - a0 == 2 * ABSORB + 3, "R4", "words accepted under stall",
            acc_cnt - a0, 2 * ABSORB + 3);
        chk(up_ready == 1'b0, "R4", "ready closed", up_ready, 0);
        chk(dn_valid == 1'b1, "R6", "valid while stored", dn_valid, 1);
        t_drain();
        chk(out_cnt - o0 == 2 * ABSORB + 3, "R3", "no word lost",
            out_cnt - o0, 2 * ABSORB + 3);
    endtask

    task automatic t_random();
        int a0;
        int o0;
        step();
        a0 = acc_cnt;
        o0 = out_cnt;
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r;
            r = $urandom;
            up_valid = r[0] | r[1];
            dn_ready = (i % 200 < 60) ? r[4] & r[5] : r[4] | r[6];
            step();
        end
        t_drain();
        chk(out_cnt - o0 == acc_cnt - a0, "R3", "random traffic count",
            out_cnt - o0, acc_cnt - a0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_stream();
        t_stall();
        t_random();
        t_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule